// File: doc/BRIEF.md
# Double-Buffered Byte-Writable Output Register

This block holds the code word that feeds a 16-bit converter core. It has two stages. The first stage is an input register built from byte lanes. A host writes each lane by pulling the shared write strobe low together with that lane's own select. The second stage is the output register that drives the converter. A separate load strobe copies the first stage into it. While the load strobe stays low, the output register follows the first stage. While it is high, the output register keeps its value. This lets a host stage a new word one byte at a time and apply it to the converter in a single step.

All strobes are active-low and arrive asynchronously, so each one passes through a synchronizer chain before use. The data bus is delayed through a chain of the same depth, so a word lines up with the strobes it was presented with. Two inputs empty both stages at once, without waiting for a clock edge: an asynchronous active-low clear and an active-low power-on reset. A host with an 8-bit bus wires the same byte onto every lane and uses the selects to choose which lane takes it.

Top module: `dbuf_out_reg`

## Requirements
- R1: With the write strobe and the upper-lane select (sel_n bit 1) both low, bus bits 15..8 are stored in the upper byte of the input stage.
- R2: With the write strobe and the lower-lane select (sel_n bit 0) both low, bus bits 7..0 are stored in the lower byte of the input stage.
- R3: While the write strobe is high, or while every select is high, no byte of the input stage changes. This is visible on the code after a later load.
- R4: While the load strobe is low, the output code follows the input stage. While it is high, the output code holds its value, whatever writes occur.
- R5: With the write strobe, every select and the load strobe all low, the bus word reaches the output code on the same edge that stores it in the input stage.
- R6: A low on the clear input sets both stages to zero at once, without a clock edge. Both stages stay zero for as long as the clear is low, whatever the other inputs do.
- R7: A low on the power-on reset input sets both stages to zero, exactly as the clear input does.
- R8: A change on any strobe takes effect at the (SYNC_STAGES+1)-th rising clock edge after the change. The bus word used is the one present when that strobe change was sampled.
- R9: When the same byte is driven on both lanes, as an 8-bit host does, each select stores that byte into its own lane only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Clear of both stages, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low |
| sel_n | input | LANES | Per-lane select, active low; bit 0 is the low byte |
| ld_n | input | 1 | Load strobe for the output register, active low |
| bus_d | input | LANES*LANE_W | Host data bus |
| code_q | output | LANES*LANE_W | Code word driving the converter core |

## Verification
The bench builds the block with its defaults: two 8-bit lanes and a two-flop synchronizer. With these values a strobe takes effect at the third edge after it changes. The bench checks that exact edge, and it checks every single-lane, dual-lane and replicated-byte pattern against a reference model of both stages. The clear input is dropped between clock edges while a write and a load are still held. This shows that both stages are zero before the next edge arrives, and that the first stage holds no stale byte once the clear is released.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  parameter int unsigned DEF_LANE_W = 8;
  parameter int unsigned DEF_LANES  = 2;
  parameter int unsigned DEF_SYNC   = 2;
  // bit positions inside the synchronized strobe vector
  localparam int unsigned STB_WR  = 0;
  localparam int unsigned STB_LD  = 1;
  localparam int unsigned STB_SEL = 2;
endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbr_input_stage.sv
module dbr_input_stage #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     q,
  output logic [W-1:0]     q_next
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic take;
      assign take = wr && sel[i];
      assign q_next[i*LANE_W +: LANE_W] = take ? din[i*LANE_W +: LANE_W]
                                               : q[i*LANE_W +: LANE_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i*LANE_W +: LANE_W] <= '0;
        else        q[i*LANE_W +: LANE_W] <= q_next[i*LANE_W +: LANE_W];
      end

      // R1 R2
      lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel[i]) |=> q[i*LANE_W +: LANE_W] == $past(din[i*LANE_W +: LANE_W]));
      // R3
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel[i]) |=> $stable(q[i*LANE_W +: LANE_W]));
    end
  endgenerate
endmodule

// File: rtl/dbr_output_stage.sv
module dbr_output_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));
endmodule

// File: rtl/dbuf_out_reg.sv
module dbuf_out_reg
  import dbr_pkg::*;
#(
  parameter int unsigned LANE_W      = DEF_LANE_W,
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned W          = LANE_W * LANES,
  localparam int unsigned SW         = LANES + 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] sel_n,
  input  logic             ld_n,
  input  logic [W-1:0]     bus_d,
  output logic [W-1:0]     code_q
);
  logic          rst_n;
  logic [SW-1:0] stb_raw, stb_s;
  logic [W-1:0]  data_s, in_q, in_next;
  logic          wr_s, ld_s;
  logic [LANES-1:0] sel_s;

  assign rst_n = por_n & clr_n;

  // strobes converted to active-high before synchronizing
  assign stb_raw[STB_WR]              = ~wr_n;
  assign stb_raw[STB_LD]              = ~ld_n;
  assign stb_raw[STB_SEL +: LANES]    = ~sel_n;

  dbr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s));

  dbr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d(bus_d), .q(data_s));

  assign wr_s  = stb_s[STB_WR];
  assign ld_s  = stb_s[STB_LD];
  assign sel_s = stb_s[STB_SEL +: LANES];

  dbr_input_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .wr(wr_s), .sel(sel_s), .din(data_s),
    .q(in_q), .q_next(in_next));

  dbr_output_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .ld(ld_s), .d(in_next), .q(code_q));

  // R4
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && !wr_s) |=> code_q == $past(in_q));
  // R5
  flow_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && wr_s && (&sel_s)) |=> code_q == $past(data_s));
  // R6 R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_q == '0 && in_q == '0));
endmodule

// File: tb/dbuf_out_reg_bench.sv
module dbuf_out_reg_bench;
  localparam int unsigned W = 16;

  logic clk = 1'b0;
  logic por_n, clr_n, wr_n, ld_n;
  logic [1:0] sel_n;
  logic [W-1:0] bus_d, code_q;
  logic [W-1:0] m_in, m_out;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  dbuf_out_reg u_dbuf_out_reg (
    .clk(clk), .por_n(por_n), .clr_n(clr_n), .wr_n(wr_n), .sel_n(sel_n),
    .ld_n(ld_n), .bus_d(bus_d), .code_q(code_q));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [W-1:0] exp);
    total++;
    if (code_q !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, code_q, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    wr_n = 1; sel_n = 2'b11; ld_n = 1;
    cyc(5);
  endtask

  // drive one strobe pattern, let it settle, update model, release, compare
  task automatic apply(string req, logic w, logic [1:0] s, logic l, logic [W-1:0] d);
    wr_n = w; sel_n = s; ld_n = l; bus_d = d;
    cyc(5);
    if (!w && !s[1]) m_in[15:8] = d[15:8];
    if (!w && !s[0]) m_in[7:0]  = d[7:0];
    if (!l) m_out = m_in;
    chk(req, m_out);
    idle();
    chk(req, m_out);
  endtask

  task automatic t_reset();
    chk("R7", '0);
    m_in = '0; m_out = '0;
  endtask

  task automatic t_lanes();
    apply("R1", 0, 2'b01, 1, 16'hA5C3);
    apply("R1", 1, 2'b11, 0, 16'h0000);
    apply("R2", 0, 2'b10, 1, 16'h1234);
    apply("R2", 1, 2'b11, 0, 16'hFFFF);
  endtask

  task automatic t_inhibit();
    apply("R3", 1, 2'b00, 1, 16'hDEAD);
    apply("R3", 0, 2'b11, 1, 16'hBEEF);
    apply("R3", 1, 2'b11, 0, 16'h0000);
  endtask

  task automatic t_hold();
    apply("R4", 0, 2'b00, 1, 16'h5A5A);
    chk("R4", m_out);
    apply("R4", 1, 2'b11, 0, 16'h0000);
  endtask

  task automatic t_flow();
    apply("R5", 0, 2'b00, 0, 16'hC0DE);
    apply("R5", 0, 2'b00, 0, 16'h0001);
  endtask

  task automatic t_latency();
    logic [W-1:0] old = m_out;
    wr_n = 0; sel_n = 2'b00; ld_n = 0; bus_d = 16'h7E81;
    cyc(2);
    chk("R8", old);
    cyc(1);
    chk("R8", 16'h7E81);
    m_in = 16'h7E81; m_out = 16'h7E81;
    idle();
  endtask

  task automatic t_byte_host();
    apply("R9", 0, 2'b10, 1, 16'h3C3C);
    apply("R9", 0, 2'b01, 0, 16'h9696);
    apply("R9", 0, 2'b10, 0, 16'h4242);
  endtask

  task automatic t_clear();
    wr_n = 0; sel_n = 2'b00; ld_n = 0; bus_d = 16'hFACE;
    cyc(5);
    m_in = 16'hFACE; m_out = 16'hFACE;
    chk("R6", 16'hFACE);
    #1 clr_n = 0;
    #0.5;
    chk("R6", '0);
    cyc(3);
    chk("R6", '0);
    wr_n = 1; sel_n = 2'b11; ld_n = 1;
    cyc(2);
    clr_n = 1;
    m_in = '0; m_out = '0;
    cyc(5);
    chk("R6", '0);
    apply("R6", 1, 2'b11, 0, 16'hAAAA);
  endtask

  task automatic t_por();
    apply("R7", 0, 2'b00, 0, 16'h8001);
    #1 por_n = 0;
    #0.5;
    chk("R7", '0);
    cyc(2);
    por_n = 1;
    m_in = '0; m_out = '0;
    cyc(3);
    apply("R7", 1, 2'b11, 0, 16'h0000);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic w, l;
      logic [1:0] s;
      logic [W-1:0] d;
      w = 1'($urandom); l = 1'($urandom); s = 2'($urandom); d = W'($urandom);
      apply("R4", w, s, l, d);
      if (i % 10 == 9) begin
        #1 clr_n = 0;
        #1 chk("R6", '0);
        cyc(2);
        clr_n = 1;
        m_in = '0; m_out = '0;
        cyc(3);
      end
    end
  endtask

  initial begin
    por_n = 0; clr_n = 1; wr_n = 1; sel_n = 2'b11; ld_n = 1; bus_d = '0;
    cyc(3);
    t_reset();
    por_n = 1;
    cyc(3);
    t_lanes();
    t_inhibit();
    t_hold();
    t_flow();
    t_latency();
    t_byte_host();
    t_clear();
    t_por();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule